// File: doc/BRIEF.md
# Speculative Buffering Data Cache

This block is a small, fully associative, shared L1 data cache for a processor that runs two contexts. One context is the committed (non-speculative) thread and the other runs ahead speculatively. Speculative stores stay inside the cache lines and never reach the backing store. Speculative loads leave a mark on the line they read. A committed-thread store that lands on such a marked line shows that the run-ahead thread consumed a stale value, and the block then asks the thread controller to squash it.

Each request names a line address, a word mask, a full line of write data, a read/write flag and the requesting context. The backing store is a word-masked line memory inside the block. It stands in for L2, has a fixed read latency and holds only committed data. A thread controller drives commit and squash commands; each command is held until its done pulse. The block raises a one-cycle squash request whenever speculative state has to be dropped.

Top module: `spec_dcache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1 and all other outputs are 0. Word k of backing line a holds the value a*256+k, and line data is word k at bits [k*DW +: DW].
- R2: A speculative store writes its masked words into the line and marks those words speculatively modified. Later speculative loads of that line return the stored words, and the other words come from the backing store.
- R3: The backing store never receives a write caused by a speculative request. A committed-thread load of a line that holds speculative stores is served from the backing store.
- R4: A committed-thread store always writes its masked words through to the backing store, and a miss does not allocate a line. On a hit it updates in the cache only the masked words whose speculative-modified mark is clear.
- R5: A speculative load marks the line as speculatively read only if at least one requested word lacks a speculative-modified mark. A committed-thread store that hits a speculatively read line pulses `squash_req`.
- R6: A committed-thread store that misses, or hits a line not speculatively read, does not pulse `squash_req`.
- R7: A line fill takes the lowest-index invalid line, or failing that the lowest-index line with no speculative marks. A speculative miss with no such line answers with `rsp_retry` = 1 and changes nothing.
- R8: A committed-thread load miss with no replaceable line pulses `squash_req` and returns the backing-store data without allocating.
- R9: Commit copies every speculatively modified line into the backing store, clears all speculative marks and pulses `commit_done`.
- R10: Squash invalidates speculatively modified lines, returns speculatively read lines to plain valid, clears all marks and pulses `squash_done`. No request is accepted while a command is asserted.
- R11: A response that needs no backing-store read arrives one cycle after acceptance. One that needs a read arrives L2_LAT+1 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_spec | input | 1 | 1 = speculative context, 0 = committed context |
| req_wr | input | 1 | 1 = store, 0 = load |
| req_addr | input | LAW | Line address |
| req_mask | input | WORDS | Words read or written |
| req_wdata | input | WORDS*DW | Store data, word k at [k*DW +: DW] |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_retry | output | 1 | Speculative miss found no replaceable line |
| rsp_rdata | output | WORDS*DW | Load data |
| commit_req | input | 1 | Commit command, held until `commit_done` |
| commit_done | output | 1 | Commit finished |
| squash_cmd | input | 1 | Squash command, held until `squash_done` |
| squash_done | output | 1 | Squash finished |
| squash_req | output | 1 | Pulse asking the controller to squash |

## Verification
The assertions check on every cycle that a speculatively dirty line always carries word marks and that word marks appear only in that state. They also check that a read mark sits only on a speculative line, that no speculative request or fill drives a backing write, that fills never pick a marked line, and that no line is speculative when a command's done pulse appears. Only the bench scenarios can show the data outcomes: the word merge when a committed store hits a speculatively written line, the stale-value squash, the data that commit writes back and squash discards, and the response latencies.

// File: rtl/spec_dcache_pkg.sv
package spec_dcache_pkg;
   typedef enum logic [1:0] {LN_INV, LN_VAL, LN_SV, LN_SD} line_st_e;
   typedef enum logic [1:0] {F_IDLE, F_FILL, F_CMT} ctl_st_e;
endpackage

// File: rtl/sdc_match.sv
module sdc_match #(
   parameter int NL  = 4,
   parameter int LAW = 4,
   localparam int IW = $clog2(NL)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NL-1:0]            vld,
   input  logic [NL-1:0][LAW-1:0]   tags,
   input  logic [LAW-1:0]           addr,
   output logic                     hit,
   output logic [IW-1:0]            idx
);
   logic [NL-1:0] hv;

   for (genvar g = 0; g < NL; g++) begin : g_cmp
      assign hv[g] = vld[g] && (tags[g] == addr);
   end

   always_comb begin
      idx = '0;
      for (int i = NL-1; i >= 0; i--)
         if (hv[i]) idx = IW'(i);
   end
   assign hit = |hv;

   // R7: fills never create a second copy of a line
   a_r7_single_copy: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hv));
endmodule

// File: rtl/sdc_victim.sv
module sdc_victim #(
   parameter int NL = 4,
   localparam int IW = $clog2(NL)
) (
   input  logic [NL-1:0] vld,
   input  logic [NL-1:0] busy,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NL-1; i >= 0; i--)
         if (!busy[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      for (int i = NL-1; i >= 0; i--)
         if (!vld[i]) idx = IW'(i);
   end
endmodule

// File: rtl/sdc_backing.sv
module sdc_backing #(
   parameter int LAW   = 4,
   parameter int WORDS = 4,
   parameter int DW    = 16,
   parameter int LAT   = 3,
   localparam int NA   = 1 << LAW,
   localparam int LW   = WORDS * DW,
   localparam int CW   = $clog2(LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_go,
   input  logic [LAW-1:0]   rd_addr,
   output logic             rd_done,
   output logic [LW-1:0]    rd_data,
   input  logic             wr_en,
   input  logic [LAW-1:0]   wr_addr,
   input  logic [WORDS-1:0] wr_mask,
   input  logic [LW-1:0]    wr_data
);
   if (LAT < 1)  begin : g_bad_lat  $error("LAT must be at least 1");  end
   if (LAW > 8)  begin : g_bad_law  $error("LAW must not exceed 8");   end
   if (DW < 16)  begin : g_bad_dw   $error("DW must be at least 16");  end

   logic [LW-1:0] mem [NA];
   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < NA; a++)
            for (int k = 0; k < WORDS; k++)
               mem[a][k*DW +: DW] <= DW'(a * 256 + k);
         cnt     <= '0;
         rd_data <= '0;
      end else begin
         if (wr_en)
            for (int k = 0; k < WORDS; k++)
               if (wr_mask[k]) mem[wr_addr][k*DW +: DW] <= wr_data[k*DW +: DW];
         if (rd_go) begin
            rd_data <= mem[rd_addr];
            cnt     <= CW'(LAT);
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end
   end
   assign rd_done = (cnt == CW'(1));

   // R11: one read outstanding at a time
   a_r11_single_read: assert property (@(posedge clk) disable iff (!rst_n) rd_done |-> !rd_go);
   a_r11_no_overlap:  assert property (@(posedge clk) disable iff (!rst_n) (cnt > CW'(1)) |-> !rd_go);
endmodule

// File: rtl/spec_dcache.sv
module spec_dcache
   import spec_dcache_pkg::*;
#(
   parameter int NLINES = 4,
   parameter int WORDS  = 4,
   parameter int DW     = 16,
   parameter int LAW    = 4,
   parameter int L2_LAT = 3,
   localparam int LW    = WORDS * DW,
   localparam int IW    = $clog2(NLINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_spec,
   input  logic             req_wr,
   input  logic [LAW-1:0]   req_addr,
   input  logic [WORDS-1:0] req_mask,
   input  logic [LW-1:0]    req_wdata,
   output logic             rsp_valid,
   output logic             rsp_retry,
   output logic [LW-1:0]    rsp_rdata,
   input  logic             commit_req,
   output logic             commit_done,
   input  logic             squash_cmd,
   output logic             squash_done,
   output logic             squash_req
);
   if (NLINES < 2) begin : g_bad_nl $error("NLINES must be at least 2"); end
   if (WORDS < 1)  begin : g_bad_w  $error("WORDS must be at least 1");  end

   line_st_e         ln_st  [NLINES];
   logic [LAW-1:0]   ln_tag [NLINES];
   logic             ln_sl  [NLINES];
   logic [WORDS-1:0] ln_sm  [NLINES];
   logic [LW-1:0]    ln_dat [NLINES];

   ctl_st_e          fsm;
   logic             p_spec, p_wr, p_alloc;
   logic [LAW-1:0]   p_addr;
   logic [WORDS-1:0] p_mask;
   logic [LW-1:0]    p_wdata;
   logic [IW-1:0]    p_vidx, cidx;

   logic [NLINES-1:0]          vld_v, busy_v;
   logic [NLINES-1:0][LAW-1:0] tag_v;
   logic             hit, vfound, accept, need_rd, cmd_ok, rd_done, l2_we;
   logic [IW-1:0]    hidx, vidx;
   logic [LW-1:0]    rd_data, l2_wd;
   logic [LAW-1:0]   l2_wa;
   logic [WORDS-1:0] l2_wm;

   function automatic logic [LW-1:0] wmerge(input logic [LW-1:0] o, input logic [LW-1:0] n,
                                            input logic [WORDS-1:0] m);
      logic [LW-1:0] r;
      for (int k = 0; k < WORDS; k++) r[k*DW +: DW] = m[k] ? n[k*DW +: DW] : o[k*DW +: DW];
      return r;
   endfunction

   always_comb
      for (int i = 0; i < NLINES; i++) begin
         vld_v[i]  = (ln_st[i] != LN_INV);
         busy_v[i] = ln_sl[i] | (|ln_sm[i]);
         tag_v[i]  = ln_tag[i];
      end

   sdc_match #(.NL(NLINES), .LAW(LAW)) u_match (
      .clk(clk), .rst_n(rst_n), .vld(vld_v), .tags(tag_v), .addr(req_addr),
      .hit(hit), .idx(hidx));

   sdc_victim #(.NL(NLINES)) u_victim (
      .vld(vld_v), .busy(busy_v), .found(vfound), .idx(vidx));

   assign req_ready = (fsm == F_IDLE) && !commit_req && !squash_cmd;
   assign accept    = req_valid && req_ready;
   assign cmd_ok    = (fsm == F_IDLE) && !commit_done && !squash_done;
   assign need_rd   = accept && (req_spec ? (!hit && vfound)
                                          : (!req_wr && !(hit && ln_st[hidx] != LN_SD)));

   always_comb begin
      l2_wa = req_addr;
      l2_wm = req_mask;
      l2_wd = req_wdata;
      if (fsm == F_CMT) begin
         l2_we = (ln_st[cidx] == LN_SD);
         l2_wa = ln_tag[cidx];
         l2_wm = '1;
         l2_wd = ln_dat[cidx];
      end else begin
         l2_we = accept && !req_spec && req_wr;
      end
   end

   sdc_backing #(.LAW(LAW), .WORDS(WORDS), .DW(DW), .LAT(L2_LAT)) u_l2 (
      .clk(clk), .rst_n(rst_n), .rd_go(need_rd), .rd_addr(req_addr),
      .rd_done(rd_done), .rd_data(rd_data), .wr_en(l2_we), .wr_addr(l2_wa),
      .wr_mask(l2_wm), .wr_data(l2_wd));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NLINES; i++) begin
            ln_st[i]  <= LN_INV;
            ln_tag[i] <= '0;
            ln_sl[i]  <= 1'b0;
            ln_sm[i]  <= '0;
            ln_dat[i] <= '0;
         end
         fsm <= F_IDLE;
         {p_spec, p_wr, p_alloc} <= '0;
         p_addr <= '0; p_mask <= '0; p_wdata <= '0; p_vidx <= '0; cidx <= '0;
         {rsp_valid, rsp_retry, commit_done, squash_done, squash_req} <= '0;
         rsp_rdata <= '0;
      end else begin
         {rsp_valid, rsp_retry, commit_done, squash_done, squash_req} <= '0;
         case (fsm)
            F_IDLE: begin
               if (squash_cmd && cmd_ok) begin
                  for (int i = 0; i < NLINES; i++) begin
                     if (ln_st[i] == LN_SD)      ln_st[i] <= LN_INV;
                     else if (ln_st[i] == LN_SV) ln_st[i] <= LN_VAL;
                     ln_sl[i] <= 1'b0;
                     ln_sm[i] <= '0;
                  end
                  squash_done <= 1'b1;
               end else if (commit_req && cmd_ok) begin
                  fsm  <= F_CMT;
                  cidx <= '0;
               end else if (accept) begin
                  p_spec <= req_spec; p_wr <= req_wr; p_addr <= req_addr;
                  p_mask <= req_mask; p_wdata <= req_wdata; p_vidx <= vidx;
                  p_alloc <= !hit && vfound;
                  if (req_spec) begin
                     if (hit) begin
                        rsp_valid <= 1'b1;
                        if (req_wr) begin
                           ln_dat[hidx] <= wmerge(ln_dat[hidx], req_wdata, req_mask);
                           ln_sm[hidx]  <= ln_sm[hidx] | req_mask;
                           if (|req_mask) ln_st[hidx] <= LN_SD;
                        end else begin
                           rsp_rdata <= ln_dat[hidx];
                           if (|(req_mask & ~ln_sm[hidx])) begin
                              ln_sl[hidx] <= 1'b1;
                              if (ln_st[hidx] == LN_VAL) ln_st[hidx] <= LN_SV;
                           end
                        end
                     end else if (vfound) begin
                        fsm <= F_FILL;
                     end else begin
                        rsp_valid <= 1'b1;
                        rsp_retry <= 1'b1;
                     end
                  end else if (req_wr) begin
                     rsp_valid <= 1'b1;
                     if (hit) begin
                        ln_dat[hidx] <= wmerge(ln_dat[hidx], req_wdata, req_mask & ~ln_sm[hidx]);
                        squash_req   <= ln_sl[hidx];
                     end
                  end else if (hit && ln_st[hidx] != LN_SD) begin
                     rsp_valid <= 1'b1;
                     rsp_rdata <= ln_dat[hidx];
                  end else begin
                     fsm        <= F_FILL;
                     squash_req <= !hit && !vfound;
                  end
               end
            end
            F_FILL: if (rd_done) begin
               fsm       <= F_IDLE;
               rsp_valid <= 1'b1;
               rsp_rdata <= rd_data;
               if (p_alloc) begin
                  ln_tag[p_vidx] <= p_addr;
                  ln_sm[p_vidx]  <= '0;
                  ln_sl[p_vidx]  <= 1'b0;
                  ln_dat[p_vidx] <= rd_data;
                  ln_st[p_vidx]  <= LN_VAL;
                  if (p_spec && p_wr) begin
                     ln_dat[p_vidx] <= wmerge(rd_data, p_wdata, p_mask);
                     ln_sm[p_vidx]  <= p_mask;
                     if (|p_mask) ln_st[p_vidx] <= LN_SD;
                  end else if (p_spec && |p_mask) begin
                     ln_sl[p_vidx] <= 1'b1;
                     ln_st[p_vidx] <= LN_SV;
                  end
               end
            end
            F_CMT: begin
               if (ln_st[cidx] != LN_INV) ln_st[cidx] <= LN_VAL;
               ln_sl[cidx] <= 1'b0;
               ln_sm[cidx] <= '0;
               if (cidx == IW'(NLINES-1)) begin
                  fsm         <= F_IDLE;
                  commit_done <= 1'b1;
               end else begin
                  cidx <= cidx + 1'b1;
               end
            end
            default: fsm <= F_IDLE;
         endcase
      end
   end

   // R3: speculative traffic never reaches the backing store
   a_r3_spec_no_l2:  assert property (@(posedge clk) disable iff (!rst_n) (accept && req_spec) |-> !l2_we);
   a_r3_fill_no_l2:  assert property (@(posedge clk) disable iff (!rst_n) (fsm == F_FILL) |-> !l2_we);
   // R7: fills only replace lines free of speculative marks; retry is a response
   a_r7_clean_victim: assert property (@(posedge clk) disable iff (!rst_n)
                         (fsm == F_FILL && p_alloc) |-> (!ln_sl[p_vidx] && ln_sm[p_vidx] == '0));
   a_r7_retry_rsp:   assert property (@(posedge clk) disable iff (!rst_n) rsp_retry |-> rsp_valid);

   for (genvar g = 0; g < NLINES; g++) begin : g_line_chk
      // R2: word marks and the speculative-dirty state go together
      a_r2_sd_marked: assert property (@(posedge clk) disable iff (!rst_n)
                         (ln_st[g] == LN_SD) |-> (ln_sm[g] != '0));
      a_r2_marks_sd:  assert property (@(posedge clk) disable iff (!rst_n)
                         (ln_sm[g] != '0) |-> (ln_st[g] == LN_SD));
      // R5: a read mark only on a speculative line
      a_r5_sl_state:  assert property (@(posedge clk) disable iff (!rst_n)
                         ln_sl[g] |-> (ln_st[g] == LN_SV || ln_st[g] == LN_SD));
      // R9: nothing speculative after commit
      a_r9_commit_clean: assert property (@(posedge clk) disable iff (!rst_n)
                         commit_done |-> (ln_st[g] == LN_INV || ln_st[g] == LN_VAL));
      // R10: nothing speculative after squash
      a_r10_squash_clean: assert property (@(posedge clk) disable iff (!rst_n)
                         squash_done |-> (ln_st[g] == LN_INV || ln_st[g] == LN_VAL));
   end
endmodule

// File: tb/sim_spec_dcache.sv
`timescale 1ns/1ps
module sim_spec_dcache;
   localparam int LAT = 3;

   typedef struct packed {
      logic [1:0]  op;     // 0 request, 1 commit, 2 squash
      logic        spec;
      logic        wr;
      logic [3:0]  addr;
      logic [3:0]  mask;
      logic [63:0] wd;
      logic [63:0] exp;
      logic        chk;
      logic        sq;
      logic        rt;
      logic [3:0]  lat;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 28;
   localparam vec_t TV [NV] = '{
      '{2'd0,1'b0,1'b0,4'd1,4'hF,64'h0,64'h0103_0102_0101_0100,1'b1,1'b0,1'b0,4'd4,4'd11}, // R11 miss
      '{2'd0,1'b0,1'b0,4'd1,4'hF,64'h0,64'h0103_0102_0101_0100,1'b1,1'b0,1'b0,4'd1,4'd11}, // R11 hit
      '{2'd0,1'b1,1'b1,4'd1,4'h3,64'hAAA3_AAA2_AAA1_AAA0,64'h0,1'b0,1'b0,1'b0,4'd1,4'd2},  // R2
      '{2'd0,1'b1,1'b0,4'd1,4'hF,64'h0,64'h0103_0102_AAA1_AAA0,1'b1,1'b0,1'b0,4'd1,4'd2},  // R2
      '{2'd0,1'b0,1'b0,4'd1,4'hF,64'h0,64'h0103_0102_0101_0100,1'b1,1'b0,1'b0,4'd4,4'd3},  // R3
      '{2'd0,1'b0,1'b1,4'd1,4'h5,64'hBBB3_BBB2_BBB1_BBB0,64'h0,1'b0,1'b1,1'b0,4'd1,4'd5},  // R5
      '{2'd0,1'b1,1'b0,4'd1,4'hF,64'h0,64'h0103_BBB2_AAA1_AAA0,1'b1,1'b0,1'b0,4'd1,4'd4},  // R4
      '{2'd0,1'b0,1'b0,4'd1,4'hF,64'h0,64'h0103_BBB2_0101_BBB0,1'b1,1'b0,1'b0,4'd4,4'd4},  // R4
      '{2'd0,1'b1,1'b1,4'd2,4'h8,64'hCCC3_CCC2_CCC1_CCC0,64'h0,1'b0,1'b0,1'b0,4'd4,4'd7},  // R7
      '{2'd0,1'b1,1'b0,4'd2,4'h8,64'h0,64'hCCC3_0202_0201_0200,1'b1,1'b0,1'b0,4'd1,4'd2},  // R2
      '{2'd0,1'b0,1'b1,4'd2,4'h8,64'hDDD3_DDD2_DDD1_DDD0,64'h0,1'b0,1'b0,1'b0,4'd1,4'd6},  // R6
      '{2'd0,1'b1,1'b0,4'd3,4'h1,64'h0,64'h0303_0302_0301_0300,1'b1,1'b0,1'b0,4'd4,4'd7},  // R7
      '{2'd0,1'b1,1'b0,4'd4,4'hF,64'h0,64'h0403_0402_0401_0400,1'b1,1'b0,1'b0,4'd4,4'd7},  // R7
      '{2'd0,1'b1,1'b0,4'd5,4'hF,64'h0,64'h0,1'b0,1'b0,1'b1,4'd1,4'd7},                    // R7 retry
      '{2'd0,1'b0,1'b0,4'd5,4'hF,64'h0,64'h0503_0502_0501_0500,1'b1,1'b1,1'b0,4'd4,4'd8},  // R8
      '{2'd0,1'b0,1'b0,4'd3,4'hF,64'h0,64'h0303_0302_0301_0300,1'b1,1'b0,1'b0,4'd1,4'd8},  // R8
      '{2'd1,1'b0,1'b0,4'd0,4'h0,64'h0,64'h0,1'b0,1'b0,1'b0,4'd0,4'd9},                    // R9
      '{2'd0,1'b0,1'b0,4'd1,4'hF,64'h0,64'h0103_BBB2_AAA1_AAA0,1'b1,1'b0,1'b0,4'd1,4'd9},  // R9
      '{2'd0,1'b0,1'b1,4'd3,4'h1,64'h0000_0000_0000_EEE0,64'h0,1'b0,1'b0,1'b0,4'd1,4'd9},  // R9
      '{2'd0,1'b0,1'b0,4'd5,4'hF,64'h0,64'h0503_0502_0501_0500,1'b1,1'b0,1'b0,4'd4,4'd7},  // R7
      '{2'd0,1'b0,1'b0,4'd1,4'hF,64'h0,64'h0103_BBB2_AAA1_AAA0,1'b1,1'b0,1'b0,4'd4,4'd9},  // R9
      '{2'd0,1'b1,1'b1,4'd2,4'h1,64'h0000_0000_0000_FFF0,64'h0,1'b0,1'b0,1'b0,4'd1,4'd2},  // R2
      '{2'd0,1'b1,1'b0,4'd3,4'hF,64'h0,64'h0303_0302_0301_EEE0,1'b1,1'b0,1'b0,4'd1,4'd4},  // R4
      '{2'd2,1'b0,1'b0,4'd0,4'h0,64'h0,64'h0,1'b0,1'b0,1'b0,4'd0,4'd10},                   // R10
      '{2'd0,1'b0,1'b0,4'd2,4'hF,64'h0,64'hCCC3_0202_0201_0200,1'b1,1'b0,1'b0,4'd4,4'd10}, // R10
      '{2'd0,1'b0,1'b1,4'd3,4'hF,64'h1113_1112_1111_1110,64'h0,1'b0,1'b0,1'b0,4'd1,4'd10}, // R10
      '{2'd0,1'b0,1'b0,4'd3,4'hF,64'h0,64'h1113_1112_1111_1110,1'b1,1'b0,1'b0,4'd1,4'd4},  // R4
      '{2'd0,1'b1,1'b0,4'd2,4'hF,64'h0,64'hCCC3_0202_0201_0200,1'b1,1'b0,1'b0,4'd1,4'd10}  // R10
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 1'b0, req_spec = 1'b0, req_wr = 1'b0;
   logic [3:0]  req_addr = '0, req_mask = '0;
   logic [63:0] req_wdata = '0;
   logic        commit_req = 1'b0, squash_cmd = 1'b0;
   logic        req_ready, rsp_valid, rsp_retry, commit_done, squash_done, squash_req;
   logic [63:0] rsp_rdata;
   int          n_run = 0, n_fail = 0;
   bit          ended = 1'b0;

   always #5 clk = ~clk;

   spec_dcache #(.NLINES(4), .WORDS(4), .DW(16), .LAW(4), .L2_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_spec(req_spec), .req_wr(req_wr), .req_addr(req_addr), .req_mask(req_mask),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_retry(rsp_retry),
      .rsp_rdata(rsp_rdata), .commit_req(commit_req), .commit_done(commit_done),
      .squash_cmd(squash_cmd), .squash_done(squash_done), .squash_req(squash_req));

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_req(input logic s, input logic w, input logic [3:0] a, input logic [3:0] m,
                         input logic [63:0] d, output logic [63:0] rd, output logic sq,
                         output logic rt, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_spec = s; req_wr = w; req_addr = a; req_mask = m; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      sq  = squash_req;
      while (!rsp_valid && lat < 40) begin
         @(negedge clk);
         lat++;
         sq = sq | squash_req;
      end
      rd = rsp_rdata;
      rt = rsp_retry;
   endtask

   task automatic do_cmd(input bit is_commit, input string tag);
      int n = 0;
      bit seen = 1'b0;
      @(negedge clk);
      if (is_commit) commit_req = 1'b1; else squash_cmd = 1'b1;
      #1;
      chk({tag, " ready low during command"}, {63'h0, req_ready}, 64'h0);
      while (n < 40 && !seen) begin
         @(negedge clk);
         n++;
         seen = is_commit ? commit_done : squash_done;
      end
      commit_req = 1'b0; squash_cmd = 1'b0;
      chk({tag, " done pulse"}, {63'h0, seen}, 64'h1);
   endtask

   task automatic chk_reset();
      // R1: reset state at the ports
      chk("R1 req_ready", {63'h0, req_ready}, 64'h1);
      chk("R1 outputs idle", {59'h0, rsp_valid, rsp_retry, commit_done, squash_done, squash_req}, 64'h0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] rd;
      logic        sq, rt;
      int          lat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_reset();

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d step %0d", TV[i].rq, i);
         if (TV[i].op == 2'd1) do_cmd(1'b1, tag);
         else if (TV[i].op == 2'd2) do_cmd(1'b0, tag);
         else begin
            do_req(TV[i].spec, TV[i].wr, TV[i].addr, TV[i].mask, TV[i].wd, rd, sq, rt, lat);
            if (TV[i].chk) chk({tag, " data"}, rd, TV[i].exp);
            chk({tag, " squash_req"}, {63'h0, sq}, {63'h0, TV[i].sq});
            chk({tag, " retry"}, {63'h0, rt}, {63'h0, TV[i].rt});
            chk({tag, " latency R11"}, 64'(lat), 64'(TV[i].lat));
         end
      end

      // R4 / R6: committed store miss writes through, no allocation, no squash
      do_req(1'b0, 1'b1, 4'd7, 4'hF, 64'h7773_7772_7771_7770, rd, sq, rt, lat);
      chk("R6 store miss squash_req", {63'h0, sq}, 64'h0);
      do_req(1'b0, 1'b0, 4'd7, 4'hF, 64'h0, rd, sq, rt, lat);
      chk("R4 write-through data", rd, 64'h7773_7772_7771_7770);
      chk("R4 no allocate on store miss", 64'(lat), 64'(LAT + 1));

      // R1: reset mid-run restores the backing pattern and empties the cache
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_reset();
      do_req(1'b0, 1'b0, 4'd7, 4'hF, 64'h0, rd, sq, rt, lat);
      chk("R1 backing pattern", rd, 64'h0703_0702_0701_0700);
      chk("R1 empty cache miss latency", 64'(lat), 64'(LAT + 1));

      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule